// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is the software-facing half of an I2C master. A processor programs it through a small register window. It keeps the transfer mode and a 0 to 3 byte internal (sub-)address, and works out the effective target address, which may be a 7-bit or a 10-bit address. Control writes carry START and STOP commands. Reads of the receive holding register and writes of the transmit holding register advance the transfer. A separate bit-level bus engine does the signalling on the wire. This sequencer gives that engine its write bytes over a valid/ready stream. It takes received bytes from the engine over a second valid/ready stream and holds them in a small queue.

The length of a read is set by the START/STOP combination. START alone begins a streaming read. STOP on its own marks the next byte as the last-but-one. START and STOP together request a single byte. After START, the internal-address bytes go out first, most significant byte first. On the outgoing stream, `bs_data` and `bs_last` hold steady while `bs_valid` is high and `bs_ready` is low. A byte is handed over on a cycle where both are high. The engine may hold `bs_ready` low for any number of cycles. The receive stream takes a byte only on a cycle where `rx_valid` and `rx_ready` are both high; the engine must hold or retry any other byte.

The done flag, the NACK flag and the phase indications are plain levels meant for a separate interrupt block.

Register window (byte offsets): control 0x00, mode 0x04, internal address 0x0C, status 0x20, receive holding 0x30, transmit holding 0x34. Any other offset reads zero.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the sequencer is idle, with no read or write phase. The done and NACK flags are 0, every register field is 0, `bs_valid` is 0 and `rx_ready` is 0.
- R2: A write to the mode register (0x04) stores the internal-address byte count in bits 9:8, the direction in bit 12 (1 = read) and the 7-bit device address in bits 22:16. The internal-address register (0x0C) holds 24 bits. Both read back at the same positions. A mode write with direction write enters the write phase; a mode write with direction read returns to idle.
- R3: When device-address bits 6:2 equal 11110, `tgt_addr` is {device bits 1:0, internal-address bits 7:0} and `tgt_ten` is 1. Otherwise `tgt_addr` is the zero-extended 7-bit device address and `tgt_ten` is 0.
- R4: A control write (0x00) with START (bit 0) clears the done and NACK flags. If `tgt_present` is low at that write, NACK is set, the phase does not change and no bytes are sent.
- R5: In read direction, START with STOP (bit 1) enters the last state, START alone enters the streaming read state, and STOP alone enters the last-but-one state. All three raise `phase_rd`. `rd_wind_down` is high in the last-but-one and last states.
- R6: Reading the receive holding register (0x30) in the last-but-one state moves to the last state. Reading it in the last state ends the read phase and empties the receive queue.
- R7: In write direction, STOP enters the write-last state. The next accepted transmit-holding write (0x34) sends its byte with `bs_last` = 1, sets the done flag and ends the write phase. Earlier data bytes carry `bs_last` = 0.
- R8: An accepted START sends exactly N internal-address bytes, most significant byte first, where N is the mode byte count (0 sends none). They carry `bs_last` = 0 and come before any data byte.
- R9: While `bs_valid` is high and `bs_ready` is low, `bs_valid`, `bs_data` and `bs_last` stay unchanged. A control write carrying START or STOP while `bs_valid` is high is ignored for those two bits.
- R10: A transmit-holding write outside the write phase, or while a data byte is still waiting to be sent, is dropped. A receive-holding read outside the read phase returns 0. Neither changes any state.
- R11: `rx_ready` is high only in the read phase while the queue (depth `RX_DEPTH`) is not full. Receive-holding reads return bytes in arrival order and return 0 when the queue is empty. Status bit 1 is high when the phase is read and the queue holds a byte.
- R12: Control bit 2 sets the master-enable latch and bit 3 clears it; bit 3 wins if both are set. Status bit 2 (transmit room) is master-enable AND data slot empty. Status bit 0 is done and status bit 8 is NACK.
- R13: A control write with bit 7 returns every register, flag, queue and stream to the reset state. It overrides any other bits in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only when reg_wr is low) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data for reg_addr, valid in the same cycle |
| tgt_present | input | 1 | Some target answers the current effective address |
| tgt_addr | output | 10 | Effective target address |
| tgt_ten | output | 1 | Effective address is a 10-bit address |
| bs_valid | output | 1 | Outgoing write byte valid |
| bs_ready | input | 1 | Bus engine accepts the outgoing byte |
| bs_data | output | 8 | Outgoing byte |
| bs_last | output | 1 | Stop after this byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Receive queue accepts a byte |
| rx_data | input | 8 | Received byte |
| phase_rd | output | 1 | Read phase active |
| phase_wr | output | 1 | Write phase active |
| rd_wind_down | output | 1 | Read is in the last-but-one or last state |
| done_flag | output | 1 | Write transfer completed |
| nack_flag | output | 1 | No target answered at START |

## Verification
The hardest situation to reach is a control command that arrives while the outgoing stream is stalled. Software must issue it while internal-address bytes are still queued behind a low `bs_ready`. The stimulus holds `bs_ready` low across a START. It then loads a data byte and issues a STOP before releasing the stream. A later data byte shows, through its `bs_last` value, that the STOP was discarded. A second hard-to-reach case is the receive queue filling during a read: bytes are offered until `rx_ready` drops. The last-but-one and last reads are then walked through so the flush can be seen in later reads.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  // register window offsets
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_MODE = 'h04;
  localparam int OFS_IADR = 'h0C;
  localparam int OFS_STAT = 'h20;
  localparam int OFS_RXH  = 'h30;
  localparam int OFS_TXH  = 'h34;

  // control bits
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_MEN   = 2;
  localparam int CB_MDIS  = 3;
  localparam int CB_SWRST = 7;

  // mode fields
  localparam int MF_SIZE = 8;
  localparam int MF_DIR  = 12;
  localparam int MF_DEV  = 16;

  localparam int IA_BYTES = 3;
  localparam int IA_W     = 8 * IA_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_PEN, ST_RD_LAST, ST_RD_DONE,
    ST_WR, ST_WR_LAST, ST_WR_DONE
  } seq_state_t;
endpackage

// File: rtl/i2c_seq_tgt.sv
module i2c_seq_tgt (
  input  logic [6:0] dev,
  input  logic [7:0] ia_low,
  output logic [9:0] addr,
  output logic       ten
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    ten  = (dev[6:2] == TEN_PREFIX);
    addr = ten ? {dev[1:0], ia_low} : {3'b000, dev};
  end
endmodule

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else if (flush) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/i2c_seq_emit.sv
module i2c_seq_emit import i2c_seq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ia_load,
  input  logic [1:0]      ia_size,
  input  logic [IA_W-1:0] ia_value,
  input  logic            dat_push,
  input  logic [7:0]      dat_byte,
  input  logic            dat_last,
  output logic            slot_full,
  output logic            bs_valid,
  input  logic            bs_ready,
  output logic [7:0]      bs_data,
  output logic            bs_last
);
  logic [1:0]      ia_cnt;
  logic [IA_W-1:0] ia_q;
  logic [7:0]      sd_q;
  logic            sl_q;
  logic [4:0]      sh;
  logic            fire;

  assign sh        = {ia_cnt - 2'd1, 3'b000};
  assign bs_valid  = (ia_cnt != 2'd0) || slot_full;
  assign bs_data   = (ia_cnt != 2'd0) ? 8'(ia_q >> sh) : sd_q;
  assign bs_last   = (ia_cnt == 2'd0) && slot_full && sl_q;
  assign fire      = bs_valid && bs_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_cnt <= '0; ia_q <= '0; slot_full <= 1'b0; sd_q <= '0; sl_q <= 1'b0;
    end else if (clr) begin
      ia_cnt <= '0; ia_q <= '0; slot_full <= 1'b0; sd_q <= '0; sl_q <= 1'b0;
    end else begin
      if (ia_load) begin
        ia_cnt <= ia_size;
        ia_q   <= ia_value;
      end else if (fire && ia_cnt != 2'd0) begin
        ia_cnt <= ia_cnt - 2'd1;
      end
      if (dat_push) begin
        slot_full <= 1'b1;
        sd_q      <= dat_byte;
        sl_q      <= dat_last;
      end else if (fire && ia_cnt == 2'd0) begin
        slot_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq import i2c_seq_pkg::*; #(
  parameter int RX_DEPTH = 4,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tgt_present,
  output logic [9:0]        tgt_addr,
  output logic              tgt_ten,
  output logic              bs_valid,
  input  logic              bs_ready,
  output logic [7:0]        bs_data,
  output logic              bs_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              phase_rd,
  output logic              phase_wr,
  output logic              rd_wind_down,
  output logic              done_flag,
  output logic              nack_flag
);
  seq_state_t      st, st_cmd;
  logic            men;
  logic [1:0]      ia_size;
  logic            dir_rd;
  logic [6:0]      dev;
  logic [IA_W-1:0] ia_val;

  logic wr_ctl, wr_mode, wr_iadr, wr_txh, rd_rxh;
  logic soft_rst, cmd_go, cmd_start, cmd_stop, nack_hit;
  logic tx_take, slot_full;
  logic rx_empty, rx_full, rx_pop, rx_push, rx_flush;
  logic [7:0] rx_head;

  // access decode
  assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
  assign wr_mode = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
  assign wr_iadr = reg_wr && (reg_addr == ADDR_W'(OFS_IADR));
  assign wr_txh  = reg_wr && (reg_addr == ADDR_W'(OFS_TXH));
  assign rd_rxh  = reg_rd && !reg_wr && (reg_addr == ADDR_W'(OFS_RXH));

  assign soft_rst  = wr_ctl && reg_wdata[CB_SWRST];
  assign cmd_go    = wr_ctl && !soft_rst && !bs_valid &&
                     (reg_wdata[CB_START] || reg_wdata[CB_STOP]);
  assign cmd_start = cmd_go && reg_wdata[CB_START];
  assign cmd_stop  = cmd_go && reg_wdata[CB_STOP];
  assign nack_hit  = cmd_start && !tgt_present;

  // phase decode
  assign phase_rd     = (st == ST_RD) || (st == ST_RD_PEN) || (st == ST_RD_LAST);
  assign phase_wr     = (st == ST_WR) || (st == ST_WR_LAST);
  assign rd_wind_down = (st == ST_RD_PEN) || (st == ST_RD_LAST);

  assign tx_take  = wr_txh && phase_wr && !slot_full;
  assign rx_ready = phase_rd && !rx_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd_rxh && phase_rd && !rx_empty;
  assign rx_flush = soft_rst || cmd_start || (rd_rxh && st == ST_RD_LAST);

  // state after an accepted command
  always_comb begin
    if (!dir_rd)
      st_cmd = cmd_stop ? ST_WR_LAST : ST_WR;
    else if (cmd_start && cmd_stop)
      st_cmd = ST_RD_LAST;
    else if (cmd_start)
      st_cmd = ST_RD;
    else
      st_cmd = ST_RD_PEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; men <= 1'b0; ia_size <= '0; dir_rd <= 1'b0; dev <= '0;
      ia_val <= '0; done_flag <= 1'b0; nack_flag <= 1'b0;
    end else if (soft_rst) begin
      st <= ST_IDLE; men <= 1'b0; ia_size <= '0; dir_rd <= 1'b0; dev <= '0;
      ia_val <= '0; done_flag <= 1'b0; nack_flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        if (reg_wdata[CB_MDIS])     men <= 1'b0;
        else if (reg_wdata[CB_MEN]) men <= 1'b1;
      end
      if (wr_mode) begin
        ia_size <= reg_wdata[MF_SIZE +: 2];
        dir_rd  <= reg_wdata[MF_DIR];
        dev     <= reg_wdata[MF_DEV +: 7];
        st      <= reg_wdata[MF_DIR] ? ST_IDLE : ST_WR;
      end
      if (wr_iadr) ia_val <= reg_wdata[IA_W-1:0];
      if (cmd_start) begin
        done_flag <= 1'b0;
        nack_flag <= !tgt_present;
      end
      if (cmd_go && !nack_hit) st <= st_cmd;
      if (tx_take && st == ST_WR_LAST) begin
        st        <= ST_WR_DONE;
        done_flag <= 1'b1;
      end
      if (rd_rxh) begin
        if (st == ST_RD_PEN)       st <= ST_RD_LAST;
        else if (st == ST_RD_LAST) st <= ST_RD_DONE;
      end
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_MODE): begin
        reg_rdata[MF_SIZE +: 2] = ia_size;
        reg_rdata[MF_DIR]       = dir_rd;
        reg_rdata[MF_DEV +: 7]  = dev;
      end
      ADDR_W'(OFS_IADR): reg_rdata[IA_W-1:0] = ia_val;
      ADDR_W'(OFS_STAT): begin
        reg_rdata[0] = done_flag;
        reg_rdata[1] = phase_rd && !rx_empty;
        reg_rdata[2] = men && !slot_full;
        reg_rdata[8] = nack_flag;
      end
      ADDR_W'(OFS_RXH): reg_rdata[7:0] = (phase_rd && !rx_empty) ? rx_head : 8'h00;
      default: reg_rdata = '0;
    endcase
  end

  i2c_seq_tgt u_tgt (
    .dev    (dev),
    .ia_low (ia_val[7:0]),
    .addr   (tgt_addr),
    .ten    (tgt_ten)
  );

  i2c_seq_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .ia_load   (cmd_start && tgt_present),
    .ia_size   (ia_size),
    .ia_value  (ia_val),
    .dat_push  (tx_take),
    .dat_byte  (reg_wdata[7:0]),
    .dat_last  (st == ST_WR_LAST),
    .slot_full (slot_full),
    .bs_valid  (bs_valid),
    .bs_ready  (bs_ready),
    .bs_data   (bs_data),
    .bs_last   (bs_last)
  );

  i2c_seq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (rx_pop),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk import i2c_seq_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              tgt_present,
  input logic              bs_valid,
  input logic              bs_ready,
  input logic [7:0]        bs_data,
  input logic              bs_last,
  input logic              rx_ready,
  input logic              phase_rd,
  input logic              phase_wr,
  input logic              done_flag,
  input logic              nack_flag
);
  logic swr;
  assign swr = reg_wr && (reg_addr == ADDR_W'(OFS_CTL)) && reg_wdata[CB_SWRST];

  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_valid && !bs_ready && !swr |=> bs_valid && $stable(bs_data) && $stable(bs_last));

  // R4
  nack_noact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'(OFS_CTL) && reg_wdata[CB_START] && !reg_wdata[CB_SWRST]
    && !tgt_present && !bs_valid
    |=> nack_flag && $stable(phase_rd) && $stable(phase_wr) && !bs_valid);

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_TXH)));

  // R11
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> phase_rd);

  // R13
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> !phase_rd && !phase_wr && !bs_valid && !nack_flag && !done_flag);
endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .tgt_present (tgt_present),
  .bs_valid    (bs_valid),
  .bs_ready    (bs_ready),
  .bs_data     (bs_data),
  .bs_last     (bs_last),
  .rx_ready    (rx_ready),
  .phase_rd    (phase_rd),
  .phase_wr    (phase_wr),
  .done_flag   (done_flag),
  .nack_flag   (nack_flag)
);

// File: tb/sim_i2c_txn_seq.sv
module sim_i2c_txn_seq;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tgt_present = 1'b1;
  logic [9:0]  tgt_addr;
  logic        tgt_ten;
  logic        bs_valid, bs_last;
  logic        bs_ready = 1'b1;
  logic [7:0]  bs_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        phase_rd, phase_wr, rd_wind_down, done_flag, nack_flag;

  always #2.5ns clk = ~clk;

  i2c_txn_seq #(.RX_DEPTH(DEPTH)) u0 (.*);

  int nchk = 0, nfail = 0;
  bit fin = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // states: 0 idle 1 rd 2 rd-pen 3 rd-last 4 rd-done 5 wr 6 wr-last 7 wr-done
  int m_st, m_sz, m_dir, m_dev, m_ia, m_men, m_txc, m_nack;
  int m_iac, m_iav, m_slot, m_sd, m_sl;
  int q[$];

  function automatic int e_valid(); return (m_iac > 0 || m_slot != 0) ? 1 : 0; endfunction
  function automatic int e_data();
    return (m_iac > 0) ? ((m_iav >> (8 * (m_iac - 1))) & 255) : m_sd;
  endfunction
  function automatic int e_last(); return (m_iac == 0 && m_slot != 0 && m_sl != 0) ? 1 : 0; endfunction
  function automatic int e_rd(); return (m_st >= 1 && m_st <= 3) ? 1 : 0; endfunction
  function automatic int e_wr(); return (m_st == 5 || m_st == 6) ? 1 : 0; endfunction
  function automatic int e_wd(); return (m_st == 2 || m_st == 3) ? 1 : 0; endfunction
  function automatic int e_rxr(); return (e_rd() != 0 && q.size() < DEPTH) ? 1 : 0; endfunction
  function automatic int e_ten(); return (((m_dev >> 2) & 31) == 30) ? 1 : 0; endfunction
  function automatic int e_tgt();
    return e_ten() ? (((m_dev & 3) << 8) | (m_ia & 255)) : m_dev;
  endfunction
  function automatic int e_rdata(int a);
    case (a)
      'h04: return (m_sz << 8) | (m_dir << 12) | (m_dev << 16);
      'h0C: return m_ia;
      'h20: return m_txc | ((e_rd() != 0 && q.size() > 0) ? 2 : 0)
                   | ((m_men != 0 && m_slot == 0) ? 4 : 0) | (m_nack << 8);
      'h30: return (e_rd() != 0 && q.size() > 0) ? q[0] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic mreset();
    m_st = 0; m_sz = 0; m_dir = 0; m_dev = 0; m_ia = 0; m_men = 0; m_txc = 0; m_nack = 0;
    m_iac = 0; m_iav = 0; m_slot = 0; m_sd = 0; m_sl = 0;
    q.delete();
  endtask

  task automatic mstep();
    int busy, push, fl, a, slot_pre;
    logic [31:0] d;
    bit w, r;
    busy = e_valid(); push = (rx_valid && e_rxr() != 0) ? 1 : 0; fl = 0;
    w = reg_wr; r = reg_rd && !reg_wr; a = reg_addr; d = reg_wdata; slot_pre = m_slot;
    if (busy != 0 && bs_ready) begin
      if (m_iac > 0) m_iac--; else m_slot = 0;
    end
    if (w && a == 0 && d[7]) begin mreset(); return; end
    if (w && a == 0) begin
      if (d[3]) m_men = 0; else if (d[2]) m_men = 1;
      if ((d[0] || d[1]) && busy == 0) begin
        if (d[0]) begin m_txc = 0; m_nack = 0; fl = 1; end
        if (d[0] && !tgt_present) m_nack = 1;
        else begin
          if (d[0]) begin m_iac = m_sz; m_iav = m_ia; end
          if (m_dir == 0) m_st = d[1] ? 6 : 5;
          else m_st = (d[0] && d[1]) ? 3 : (d[0] ? 1 : 2);
        end
      end
    end
    if (w && a == 'h04) begin
      m_sz = int'(d[9:8]); m_dir = int'(d[12]); m_dev = int'(d[22:16]);
      m_st = (m_dir != 0) ? 0 : 5;
    end
    if (w && a == 'h0C) m_ia = int'(d[23:0]);
    if (w && a == 'h34 && e_wr() != 0 && slot_pre == 0) begin
      m_slot = 1; m_sd = int'(d[7:0]); m_sl = (m_st == 6) ? 1 : 0;
      if (m_st == 6) begin m_st = 7; m_txc = 1; end
    end
    if (r && a == 'h30 && e_rd() != 0) begin
      if (q.size() > 0) void'(q.pop_front());
      if (m_st == 2) m_st = 3;
      else if (m_st == 3) begin m_st = 4; fl = 1; end
    end
    if (fl != 0) q.delete();
    else if (push != 0) q.push_back(int'(rx_data));
  endtask

  initial mreset();
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreset(); else mstep();
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R9 bs_valid", int'(bs_valid), e_valid());
      if (e_valid() != 0) begin
        chk("R8 bs_data", int'(bs_data), e_data());
        chk("R7 bs_last", int'(bs_last), e_last());
      end
      chk("R5 phase_rd", int'(phase_rd), e_rd());
      chk("R2 phase_wr", int'(phase_wr), e_wr());
      chk("R6 rd_wind_down", int'(rd_wind_down), e_wd());
      chk("R3 tgt_addr", int'(tgt_addr), e_tgt());
      chk("R3 tgt_ten", int'(tgt_ten), e_ten());
      chk("R11 rx_ready", int'(rx_ready), e_rxr());
      chk("R7 done_flag", int'(done_flag), m_txc);
      chk("R4 nack_flag", int'(nack_flag), m_nack);
      if (reg_rd) chk("R12 reg_rdata", int'(reg_rdata), e_rdata(int'(reg_addr)));
    end
  end

  // stream capture {last,data}
  int cap[$];
  always @(negedge clk) begin
    if (rst_n && bs_valid && bs_ready) cap.push_back({23'd0, bs_last, bs_data});
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int a, int d);
    @(posedge clk); #1ns;
    reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
    @(posedge clk); #1ns;
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(posedge clk); #1ns;
    reg_rd = 1'b1; reg_addr = 8'(a);
    @(negedge clk); d = int'(reg_rdata);
    @(posedge clk); #1ns;
    reg_rd = 1'b0;
  endtask

  task automatic feed(int b);
    @(posedge clk); #1ns;
    rx_valid = 1'b1; rx_data = 8'(b);
    @(posedge clk); #1ns;
    rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1ns;
  endtask

  task automatic finish_run();
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v;
    idle(3);
    chk("R1 bs_valid in reset", int'(bs_valid), 0);
    rst_n = 1'b1;
    idle(2);
    rd('h20, v); chk("R1 status after reset", v, 0);
    rd('h04, v); chk("R1 mode after reset", v, 0);
    chk("R1 rx_ready after reset", int'(rx_ready), 0);

    // write transfer with 2 internal-address bytes and a stalled stream
    wr(0, 'h4);
    wr('h0C, 'h001234);
    wr('h04, (2 << 8) | ('h50 << 16));
    rd('h04, v); chk("R2 mode readback", v, (2 << 8) | ('h50 << 16));
    chk("R2 write phase after mode", int'(phase_wr), 1);
    bs_ready = 1'b0;
    wr(0, 'h1);
    idle(3);
    wr('h34, 'hA5);
    rd('h20, v); chk("R12 tx room clear while slot full", v & 4, 0);
    wr(0, 'h2);                     // STOP while busy: dropped
    bs_ready = 1'b1;
    idle(6);
    chk("R9 stop ignored while busy", int'(rd_wind_down) | int'(phase_wr), 1);
    wr(0, 'h2);
    wr('h34, 'h5A);
    idle(3);
    chk("R7 done set", int'(done_flag), 1);
    chk("R7 write phase ended", int'(phase_wr), 0);
    chk("R8 byte count", cap.size(), 4);
    if (cap.size() == 4) begin
      chk("R8 first ia byte", cap[0], 'h012);
      chk("R8 second ia byte", cap[1], 'h034);
      chk("R9 data after ia, stop ignored", cap[2], 'h0A5);
      chk("R7 last byte flagged", cap[3], 'h15A);
    end
    wr('h34, 'h77);
    idle(3);
    chk("R10 tx write outside phase dropped", cap.size(), 4);

    // streaming read, 3 internal-address bytes, queue fill, wind-down
    cap.delete();
    wr('h0C, 'hABCDEF);
    wr('h04, (3 << 8) | (1 << 12) | ('h22 << 16));
    chk("R2 read mode idles", int'(phase_rd) | int'(phase_wr), 0);
    rd('h30, v); chk("R10 read outside phase", v, 0);
    wr(0, 'h1);
    idle(5);
    chk("R8 three ia bytes", cap.size(), 3);
    if (cap.size() == 3) begin
      chk("R8 msb first", cap[0], 'hAB);
      chk("R8 lsb last", cap[2], 'hEF);
    end
    for (int i = 1; i <= 5; i++) feed(i * 'h11);
    chk("R11 queue full", int'(rx_ready), 0);
    rd('h20, v); chk("R11 rx avail", v & 2, 2);
    rd('h30, v); chk("R11 first byte", v, 'h11);
    wr(0, 'h2);
    chk("R5 stop alone wind-down", int'(rd_wind_down), 1);
    rd('h30, v); chk("R6 penultimate byte", v, 'h22);
    chk("R6 still reading", int'(phase_rd), 1);
    rd('h30, v); chk("R6 last byte", v, 'h33);
    chk("R6 read ended", int'(phase_rd), 0);
    rd('h30, v); chk("R6 queue flushed", v, 0);

    // single-byte read
    wr(0, 'h3);
    chk("R5 start+stop last state", int'(rd_wind_down), 1);
    idle(4);
    feed('h66);
    rd('h30, v); chk("R5 single byte", v, 'h66);
    chk("R5 single read ended", int'(phase_rd), 0);

    // 10-bit target
    wr('h04, ('h7A << 16) | (1 << 12));
    wr('h0C, 'h0000C5);
    chk("R3 ten-bit address", int'(tgt_addr), 'h2C5);
    chk("R3 ten-bit flag", int'(tgt_ten), 1);

    // absent target
    tgt_present = 1'b0;
    wr(0, 'h1);
    idle(1);
    chk("R4 nack set", int'(nack_flag), 1);
    chk("R4 no phase change", int'(phase_rd), 0);
    chk("R4 no bytes", int'(bs_valid), 0);
    tgt_present = 1'b1;
    wr(0, 'h1);
    chk("R4 nack cleared", int'(nack_flag), 0);
    idle(2);

    // master enable
    wr(0, 'hC);
    rd('h20, v); chk("R12 disable wins", v & 4, 0);
    wr(0, 'h4);
    rd('h20, v); chk("R12 enable", v & 4, 4);

    // soft reset
    feed('h99);
    wr(0, 'h81);
    rd('h04, v); chk("R13 mode cleared", v, 0);
    rd('h20, v); chk("R13 status cleared", v, 0);
    chk("R13 idle", int'(phase_rd) | int'(phase_wr) | int'(bs_valid), 0);
    idle(3);
    finish_run();
  end
endmodule